// File: doc/BRIEF.md
# Handshake-Driven Add/Subtract Sequencer

This block is a small controller and datapath that collects two 3-bit operands from a slow external party and combines them. An active-low start input begins a run. The controller first clears a 4-bit result register. It then raises a request line and waits for the other side to assert ready with an operand on the bus. When ready is seen, the operand is captured into an operand register and the request is dropped. The controller then waits for ready to fall before it can raise the next request.

The first operand is always accumulated into the cleared result by addition, so the result then equals that operand. The second operand is added to or subtracted from the result, as chosen by the function input, and the sum wraps modulo 16. The machine then parks. A new run needs the start input to return high and then go low again. The start and ready inputs each pass through a two-stage synchronizer, so the other party may run on an unrelated clock or be a person at a switch.

Top module: `hsk_addsub_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `req_out` is 0 and `result_q` is 0.
- R2: No run starts while `go_n` is held at 1. `req_out` stays 0 and `result_q` stays unchanged.
- R3: Each run issues exactly two requests. Each request stays high until ready is seen high, and then it falls.
- R4: `req_out` never rises while the synchronized ready is still high. Keeping ready high for longer keeps the request low for that whole time.
- R5: At the start of a run, `result_q` is cleared to 0 synchronously before the first request is raised.
- R6: After the first operand is captured, `result_q` equals that operand zero-extended to 4 bits. This holds for either value of `func_sel`.
- R7: After the second operand is captured, `result_q` becomes (op1 + op2) mod 16 when `func_sel` is 1, or (op1 - op2) mod 16 when `func_sel` is 0.
- R8: After a run completes with `go_n` still low, no further request is raised and `result_q` holds until `go_n` has returned to 1 and fallen again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_n | input | 1 | Active-low start command (asynchronous, synchronized inside) |
| func_sel | input | 1 | Second operation: 1 = add, 0 = subtract |
| rdy_in | input | 1 | Operand-ready handshake from the data source (asynchronous) |
| opnd_in | input | 3 | Operand bus, valid while `rdy_in` is high |
| req_out | output | 1 | Operand request to the data source |
| result_q | output | 4 | Result register contents |

## Verification
The hardest situation to produce is a data source that keeps ready high long after the request has dropped. In that case the controller must hold off the second request rather than take stale data. The stimulus reaches it by keeping ready high for a varying number of extra cycles after each request falls, and it checks that the request stays low during that time. A second hard case is a start input that stays low after completion, which must not retrigger a run. Every run therefore holds `go_n` low for a while after the result appears. Across the full sweep of operand pairs and both functions, the function input is also driven to the opposite value during the first operand, to show that the first accumulation always adds.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int OPND_W     = 3;
    localparam int RES_W      = 4;
    localparam int SYNC_DEPTH = 2;

    typedef logic [OPND_W-1:0] opnd_t;
    typedef logic [RES_W-1:0]  res_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLEAR,
        S_REQ_A,
        S_ACC_A,
        S_DROP_A,
        S_REQ_B,
        S_ACC_B,
        S_DROP_B,
        S_HOLD
    } seq_state_e;

    typedef struct packed {
        logic ld_a;     // capture operand bus into A
        logic ld_b;     // load combiner output into B
        logic clr_b_n;  // active-low synchronous clear of B
        logic add_sel;  // 1 = add, 0 = subtract
    } ctl_t;

    function automatic res_t combine(input res_t acc, input opnd_t op, input logic add);
        res_t ext;
        ext = res_t'(op);
        return add ? res_t'(acc + ext) : res_t'(acc - ext);
    endfunction
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d_in};
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go_s,
    input  logic       rdy_s,
    input  logic       func_sel,
    output logic       req_o,
    output ctl_t       ctl_o,
    output seq_state_e state_o
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        ctl_o   = '{ld_a: 1'b0, ld_b: 1'b0, clr_b_n: 1'b1, add_sel: 1'b1};
        req_o   = 1'b0;
        unique case (state_q)
            S_IDLE:   if (!go_s) state_d = S_CLEAR;
            S_CLEAR: begin
                ctl_o.clr_b_n = 1'b0;
                if (!rdy_s) state_d = S_REQ_A;
            end
            S_REQ_A: begin
                req_o = 1'b1;
                if (rdy_s) begin
                    ctl_o.ld_a = 1'b1;
                    state_d    = S_ACC_A;
                end
            end
            S_ACC_A: begin
                ctl_o.ld_b    = 1'b1;
                ctl_o.add_sel = 1'b1;
                state_d       = S_DROP_A;
            end
            S_DROP_A: if (!rdy_s) state_d = S_REQ_B;
            S_REQ_B: begin
                req_o = 1'b1;
                if (rdy_s) begin
                    ctl_o.ld_a = 1'b1;
                    state_d    = S_ACC_B;
                end
            end
            S_ACC_B: begin
                ctl_o.ld_b    = 1'b1;
                ctl_o.add_sel = func_sel;
                state_d       = S_DROP_B;
            end
            S_DROP_B: if (!rdy_s) state_d = S_HOLD;
            S_HOLD:   if (go_s) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
    import seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  ctl_i,
    input  opnd_t opnd_i,
    output res_t  res_o
);
    opnd_t a_q;
    res_t  b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (ctl_i.ld_a) a_q <= opnd_i;
            if (!ctl_i.clr_b_n)  b_q <= '0;
            else if (ctl_i.ld_b) b_q <= combine(b_q, a_q, ctl_i.add_sel);
        end
    end

    assign res_o = b_q;
endmodule

// File: rtl/hsk_addsub_seq.sv
module hsk_addsub_seq
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go_n,
    input  logic              func_sel,
    input  logic              rdy_in,
    input  logic [OPND_W-1:0] opnd_in,
    output logic              req_out,
    output logic [RES_W-1:0]  result_q
);
    logic       go_s;
    logic       rdy_s;
    ctl_t       ctl;
    seq_state_e ctl_state;

    seq_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) go_sync_i (
        .clk(clk), .rst(rst), .d_in(go_n), .q_out(go_s)
    );

    seq_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) rdy_sync_i (
        .clk(clk), .rst(rst), .d_in(rdy_in), .q_out(rdy_s)
    );

    seq_ctrl ctrl_i (
        .clk(clk), .rst(rst), .go_s(go_s), .rdy_s(rdy_s), .func_sel(func_sel),
        .req_o(req_out), .ctl_o(ctl), .state_o(ctl_state)
    );

    seq_datapath dp_i (
        .clk(clk), .rst(rst), .ctl_i(ctl), .opnd_i(opnd_in), .res_o(result_q)
    );
endmodule

// File: rtl/seq_checker.sv
module seq_checker
    import seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_out,
    input logic [3:0] result_q,
    input logic       go_s,
    input logic       rdy_s,
    input ctl_t       ctl,
    input seq_state_e ctl_state
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!req_out && result_q == 4'd0));

    assert_no_start_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_state == S_IDLE && go_s) |=> (ctl_state == S_IDLE && !req_out));

    assert_req_falls_R3: assert property (@(posedge clk) disable iff (rst)
        (req_out && rdy_s) |=> !req_out);

    assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
        (req_out && !rdy_s) |=> req_out);

    assert_no_req_while_rdy_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(req_out) |-> !rdy_s);

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        !ctl.clr_b_n |=> result_q == 4'd0);

    assert_single_ctl_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.ld_a, ctl.ld_b, !ctl.clr_b_n}));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl_state == S_HOLD) |=> ($stable(result_q) && !req_out));
endmodule

bind hsk_addsub_seq seq_checker chk_i (
    .clk(clk), .rst(rst), .req_out(req_out), .result_q(result_q),
    .go_s(go_s), .rdy_s(rdy_s), .ctl(ctl), .ctl_state(ctl_state)
);

// File: tb/hsk_addsub_seq_tb_top.sv
module hsk_addsub_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       go_n;
    logic       func_sel;
    logic       rdy_in;
    logic [2:0] opnd_in;
    logic       req_out;
    logic [3:0] result_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    hsk_addsub_seq dut_i (
        .clk(clk), .rst(rst), .go_n(go_n), .func_sel(func_sel),
        .rdy_in(rdy_in), .opnd_in(opnd_in), .req_out(req_out), .result_q(result_q)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_req(input logic val, input string req);
        int k = 0;
        while (req_out !== val && k < 100) begin
            @(negedge clk);
            k++;
        end
        check(req_out === val, req, int'(req_out), int'(val));
    endtask

    task automatic run_seq(input int a, input int b, input bit f, input int extra);
        int exp_r;
        logic [3:0] held;
        @(negedge clk);
        go_n     = 1'b0;
        func_sel = ~f;
        wait_req(1'b1, "R3 first request");
        check(result_q == 4'd0, "R5 cleared before first request", result_q, 0);
        opnd_in = 3'(a);
        rdy_in  = 1'b1;
        wait_req(1'b0, "R3 first request drops");
        for (int i = 0; i < extra + 3; i++) begin
            @(negedge clk);
            check(req_out == 1'b0, "R4 no request while ready high", req_out, 0);
        end
        opnd_in = 3'h0;
        rdy_in  = 1'b0;
        func_sel = f;
        wait_req(1'b1, "R3 second request");
        check(result_q == 4'(a), "R6 first operand accumulated by add", result_q, a);
        opnd_in = 3'(b);
        rdy_in  = 1'b1;
        wait_req(1'b0, "R3 second request drops");
        repeat (extra + 1) @(negedge clk);
        rdy_in = 1'b0;
        repeat (6) @(negedge clk);
        exp_r = f ? ((a + b) & 15) : ((a - b) & 15);
        check(result_q == 4'(exp_r), f ? "R7 add result" : "R7 subtract result", result_q, exp_r);
        held = result_q;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check(req_out == 1'b0 && result_q == held, "R8 no restart while GO low",
                  int'(req_out), 0);
        end
        go_n = 1'b1;
        repeat (4) @(negedge clk);
        check(result_q == held && req_out == 1'b0, "R8 result held after GO release",
              result_q, held);
    endtask

    initial begin
        rst = 1'b1; go_n = 1'b1; func_sel = 1'b1; rdy_in = 1'b0; opnd_in = 3'h0;
        repeat (3) @(negedge clk);
        check(req_out == 1'b0 && result_q == 4'd0, "R1 reset state", result_q, 0);
        rst = 1'b0;
        @(negedge clk);
        check(req_out == 1'b0 && result_q == 4'd0, "R1 after reset", result_q, 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            check(req_out == 1'b0 && result_q == 4'd0, "R2 GO high no start", req_out, 0);
        end
        for (int f = 0; f < 2; f++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++)
                    run_seq(a, b, f[0], (a + b) % 4);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule